// File: doc/BRIEF.md
# Single-Wire Sync Response Generator

This block answers a host's speed-calibration request on a shared, bidirectional single-wire debug line. The host first holds the line low for a long time. It then releases the line and briefly drives it high itself. Separate logic recognises that request and pulses `start`. The generator then waits a short guard interval, so the host has time to stop driving. After that it pulls the line low for a fixed number of debug-clock cycles. The host times that low pulse to learn the target's bit rate.

When the low pulse ends, the block drives the line actively high for a single cycle. This gives a sharp rising edge instead of a slow pull-up rise. It then releases the line to high impedance. The output value and the tri-state enable are separate ports, and the pad cell combines them. `busy` covers the whole sequence, and `done` marks its completion.

Top module: `sync_resp_gen`

## Requirements
- R1: While `rst` is high, and in every idle cycle after it, `pin_oe`, `busy` and `done` are 0, whatever `start` does during reset.
- R2: A `start` pulse that is accepted in idle makes `busy` rise at the next clock edge. A guard phase of exactly GAP_CYCLES (default 16) cycles follows, during which `busy`=1 and `pin_oe`=0.
- R3: Right after the guard phase, the block drives the line low (`pin_oe`=1, `pin_out`=0) for exactly LOW_CYCLES (default 128) consecutive cycles.
- R4: Right after the low phase, the block drives the line high (`pin_oe`=1, `pin_out`=1) for exactly one cycle.
- R5: In the cycle after the high cycle, `pin_oe`=0 and `busy`=0, and `done`=1 for that one cycle only.
- R6: A `start` that arrives while `busy` is 1 is ignored. The phase lengths of the running sequence do not change, and no second sequence follows it.
- R7: `pin_oe` is 1 only inside the low phase and the high phase. The phase order is always guard, then low, then high.
- R8: A `start` given in the cycle where `done` is 1 is accepted. The new sequence has the same phase lengths.
- R9: A `start` while `pin_in` is 0 (line still held low) is ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a sync response |
| pin_in | input | 1 | Sampled level of the debug line |
| pin_out | output | 1 | Value to drive onto the line when enabled |
| pin_oe | output | 1 | Tri-state enable for the line driver |
| busy | output | 1 | High from the accepted start until release |
| done | output | 1 | One-cycle completion pulse |

## Verification
`start` is sampled at a clock edge, and `busy` reads 1 at the falling edge that follows. From there the bench expects the guard, low and high phases to fill exactly GAP_CYCLES, LOW_CYCLES and 1 falling-edge samples. The release with `done` comes at the next sample, and `done` must be gone one sample later. The bench drives every input on the falling edge and samples every output on the falling edge, half a period away from the edge where state changes. It does not look for an edge at a fixed time. It classifies each sample by phase and compares the counted lengths with the parameters. It then repeats the sequence with a stray `start` placed at each offset in turn, from the first sample to the last sample of the sequence.

// File: rtl/sync_resp_pkg.sv
package sync_resp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_LOW  = 2'd2,
        PH_KICK = 2'd3
    } phase_e;

    // bits needed to hold the values 0 .. n-1
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sync_resp_timer.sv
module sync_resp_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sync_resp_fsm.sv
module sync_resp_fsm
    import sync_resp_pkg::*;
#(
    parameter int GAP_CYCLES = 16,
    parameter int LOW_CYCLES = 128,
    parameter int W          = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         pin_in,
    input  logic         expired,
    output phase_e       phase,
    output logic         load,
    output logic [W-1:0] load_val
);
    localparam logic [W-1:0] GAP_LOAD = W'(GAP_CYCLES - 1);
    localparam logic [W-1:0] LOW_LOAD = W'(LOW_CYCLES - 1);

    phase_e phase_q, phase_d;

    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        unique case (phase_q)
            PH_IDLE: if (start && pin_in) begin
                phase_d  = PH_GAP;
                load     = 1'b1;
                load_val = GAP_LOAD;
            end
            PH_GAP: if (expired) begin
                phase_d  = PH_LOW;
                load     = 1'b1;
                load_val = LOW_LOAD;
            end
            PH_LOW: if (expired) begin
                phase_d = PH_KICK;
            end
            PH_KICK: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/sync_resp_drive.sv
module sync_resp_drive
    import sync_resp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    output logic   pin_out,
    output logic   pin_oe,
    output logic   busy,
    output logic   done
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= (phase == PH_KICK);
    end

    assign pin_oe  = (phase == PH_LOW) || (phase == PH_KICK);
    assign pin_out = (phase == PH_KICK);
    assign busy    = (phase != PH_IDLE);
    assign done    = done_q;
endmodule

// File: rtl/sync_resp_gen.sv
module sync_resp_gen
    import sync_resp_pkg::*;
#(
    parameter int GAP_CYCLES = 16,
    parameter int LOW_CYCLES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic busy,
    output logic done
);
    localparam int TW = cnt_bits(max_of(GAP_CYCLES, LOW_CYCLES));

    phase_e        phase;
    logic          load;
    logic [TW-1:0] load_val;
    logic          expired;

    sync_resp_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sync_resp_fsm #(
        .GAP_CYCLES (GAP_CYCLES),
        .LOW_CYCLES (LOW_CYCLES),
        .W          (TW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pin_in   (pin_in),
        .expired  (expired),
        .phase    (phase),
        .load     (load),
        .load_val (load_val)
    );

    sync_resp_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .busy    (busy),
        .done    (done)
    );
endmodule

// File: rtl/sync_resp_gen_chk.sv
module sync_resp_gen_chk #(
    parameter int GAP_CYCLES = 16,
    parameter int LOW_CYCLES = 128
) (
    input logic clk,
    input logic rst,
    input logic pin_out,
    input logic pin_oe,
    input logic busy,
    input logic done
);
    logic [15:0] gap_run;
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_run <= '0;
            low_run <= '0;
        end else begin
            gap_run <= (busy && !pin_oe) ? gap_run + 16'd1 : 16'd0;
            low_run <= (pin_oe && !pin_out) ? low_run + 16'd1 : 16'd0;
        end
    end

    // R1: no drive while reset is applied
    always @(posedge clk) begin
        if (rst) assert_reset_quiet_R1: assert (!pin_oe && !busy);
    end

    assert_gap_len_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && !pin_out && !$past(pin_oe)) |-> gap_run == 16'(GAP_CYCLES));

    assert_low_len_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && pin_out) |-> low_run == 16'(LOW_CYCLES));

    assert_kick_single_R4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && pin_out) |=> !pin_oe);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && pin_out) |=> (done && !busy));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_oe_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> busy);

    assert_low_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_oe) |-> !pin_out);
endmodule

bind sync_resp_gen sync_resp_gen_chk #(
    .GAP_CYCLES (GAP_CYCLES),
    .LOW_CYCLES (LOW_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .busy    (busy),
    .done    (done)
);

// File: tb/sync_resp_gen_bench.sv
module sync_resp_gen_bench;
    localparam int GAP = 16;
    localparam int LOW = 128;
    localparam int SEQ = GAP + LOW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic pin_in = 1'b1;
    logic pin_out, pin_oe, busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sync_resp_gen #(.GAP_CYCLES(GAP), .LOW_CYCLES(LOW)) u_sync_resp_gen (
        .clk(clk), .rst(rst), .start(start), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts a sequence on the current falling edge, optionally pokes start again
    // at sample number poke, and checks the phase lengths and the release.
    task automatic run_seq(input int poke, input bit b2b, input string tag);
        int g = 0;
        int l = 0;
        int h = 0;
        int order_err = 0;
        int n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < 400) begin
            n++;
            if (!busy) break;
            if (!pin_oe) begin
                if (l > 0 || h > 0) order_err++;
                g++;
            end else if (!pin_out) begin
                if (h > 0) order_err++;
                l++;
            end else begin
                h++;
            end
            start = (n == poke);
            @(negedge clk);
            start = 1'b0;
        end
        check(g == GAP, {"R2 guard length ", tag}, g, GAP);
        check(l == LOW, {"R3 low length ", tag}, l, LOW);
        check(h == 1, {"R4 high length ", tag}, h, 1);
        check(order_err == 0, {"R7 phase order ", tag}, order_err, 0);
        check(done == 1'b1, {"R5 done at release ", tag}, int'(done), 1);
        check(pin_oe == 1'b0, {"R5 released ", tag}, int'(pin_oe), 0);
        if (!b2b) begin
            @(negedge clk);
            check(done == 1'b0, {"R5 done one cycle ", tag}, int'(done), 0);
            check(busy == 1'b0 && pin_oe == 1'b0, {"R6 no restart ", tag}, int'(busy), 0);
        end
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: start held during reset must not begin anything
        start = 1'b1;
        repeat (4) @(negedge clk);
        check(!pin_oe && !busy && !done, "R1 reset state", int'({pin_oe, busy, done}), 0);
        start = 1'b0;
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!pin_oe && !busy && !done, "R1 idle after reset", int'({pin_oe, busy, done}), 0);
        end

        // R9: line still low, start ignored
        pin_in = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!busy && !pin_oe, "R9 start with line low", int'(busy), 0);
        @(negedge clk);
        check(!busy, "R9 still idle", int'(busy), 0);
        pin_in = 1'b1;

        // basic sequence
        run_seq(0, 1'b0, "plain");

        // R6: stray start at every offset inside the sequence
        for (int p = 1; p <= SEQ; p++) begin
            run_seq(p, 1'b0, "poke");
        end

        // R8: back-to-back restart on the done cycle
        run_seq(0, 1'b1, "b2b first");
        run_seq(0, 1'b0, "R8 b2b second");

        repeat (3) @(negedge clk);
        check(!pin_oe && !busy, "R7 idle after all", int'(pin_oe), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule